// File: doc/BRIEF.md
# Automatic Command Response Error Checker

This block watches the command line of an SD host after the controller has sent an automatically generated command. That command is either the stop command that ends a multi-block transfer or the block-count command sent before one. Once the command's end bit has gone out, the block is armed. It waits for the card's 48-bit response and samples one bit per SD clock, using a single-cycle sampling enable in the system clock domain. For each response it decides whether a timeout, a CRC mismatch, a bad end bit or a wrong command index occurred. It also covers the case where the stop command could not be sent at all. The result goes into a latched status byte and is announced by a one-cycle strobe.

A response starts with a 0 start bit and a 0 transmission bit. Then come a 6-bit command index, a 32-bit argument, a 7-bit CRC and a 1 end bit, most significant bit first. The CRC uses the polynomial x^7+x^3+1 with a zero seed. It covers the first 40 bits, start bit included. A timeout or a not-executed report carries no other error bits. When the failing command was the block-count command, the two "not issued" indications stay at 0.

Top module: `ac_resp_check`

## Requirements
- R1: After `launch`, the block counts sampling ticks that see the line high. The 64th such tick raises a timeout, reported as status bit 1. A start bit (0) seen on any of the first 64 ticks is accepted as a response.
- R2: After a complete 48-bit response, status bit 2 is set if the 7-bit CRC received does not equal the CRC7 (x^7+x^3+1, zero seed) of the first 40 bits.
- R3: Status bit 3 is set if the 48th response bit (the end bit) is 0.
- R4: Status bit 4 is set if the 6 index bits (response bits 2 to 7, MSB first) differ from `launch_idx` captured at launch.
- R5: A timeout report has status bits 4:2 at 0.
- R6: Status layout: bit0 stop not executed, bit1 timeout, bit2 CRC, bit3 end bit, bit4 index, bit7 pending command blocked. Bits 6:5 always read 0. The status is 0 after reset.
- R7: A `skip` pulse while `xfer_active` is 1 reports status 8'h01, with bits 7 and 4:1 at 0. A `skip` pulse while `xfer_active` is 0 changes nothing.
- R8: Status bit 7 is set together with any of bits 4:1 only when the command was a stop command (`launch_kind` 0) and `cmd_pending` is 1. For a block-count command (`launch_kind` 1), bits 7 and 0 are 0.
- R9: A response without errors produces no strobe and leaves the status unchanged.
- R10: Each report loads the status and raises `err_strobe` for exactly one cycle, one clock after the deciding tick. The status then holds until `clr` sets it to 0. A report in the same cycle as `clr` takes precedence.
- R11: `cmd_in` is sampled only in cycles where `sd_tick` is 1. Its value in other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sd_tick | input | 1 | One-cycle sampling enable, one per SD clock |
| cmd_in | input | 1 | Serial command-line level from the card |
| launch | input | 1 | Pulse at the end bit of the automatic command; arms the checker |
| launch_kind | input | 1 | 0 = stop command, 1 = block-count command |
| launch_idx | input | 6 | Index of the command that was issued |
| skip | input | 1 | Pulse: the stop command could not be issued |
| xfer_active | input | 1 | The multi-block transfer actually started |
| cmd_pending | input | 1 | A non-data command is queued behind the automatic one |
| clr | input | 1 | Pulse that clears the latched status |
| status | output | 8 | Latched error status byte |
| err_strobe | output | 1 | One-cycle pulse when the status is loaded |

## Verification
The assertions assume that `skip` never arrives in the same cycle as the end of a response or a timeout. They also assume that reports are at least two cycles apart, so each strobe stands alone. The bench serializes its scenarios and clears the status between them, so both conditions always hold. It covers every command index with clean and mismatching responses, corrupted CRC and end bits, and start delays on both sides of the 64-tick limit. It also puts the inverted bit on the command line in every cycle without a tick, so any sampling outside a tick shows up as an error.

// File: rtl/ac_pkg.sv
package ac_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RECV = 2'd2
   } ac_state_e;

   typedef enum logic {
      SRC_STOP  = 1'b0,
      SRC_COUNT = 1'b1
   } ac_src_e;

   typedef struct packed {
      logic tmo;
      logic crc;
      logic endb;
      logic idx;
   } ac_err_t;

   localparam int unsigned POS_NE   = 0;
   localparam int unsigned POS_TMO  = 1;
   localparam int unsigned POS_CRC  = 2;
   localparam int unsigned POS_END  = 3;
   localparam int unsigned POS_IDX  = 4;
   localparam int unsigned POS_CNI  = 7;
   localparam int unsigned STAT_W   = 8;
endpackage

// File: rtl/ac_crc_ser.sv
module ac_crc_ser #(
   parameter int unsigned        W    = 7,
   parameter logic [W-1:0]       POLY = 7'h09
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc
);
   logic         fb;
   logic [W-1:0] nxt;

   if (W < 2) begin : g_bad_w
      $error("ac_crc_ser: W must be at least 2");
   end

   assign fb = din ^ crc[W-1];

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         assign nxt[i] = POLY[i] & fb;
      end else begin : g_upper
         assign nxt[i] = crc[i-1] ^ (POLY[i] & fb);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= '0;
      else if (clr) crc <= '0;
      else if (en)  crc <= nxt;
   end
endmodule

// File: rtl/ac_tmo.sv
module ac_tmo #(
   parameter int unsigned LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic expire
);
   localparam int unsigned TW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
   localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

   logic [TW-1:0] cnt;

   if (LIMIT < 2) begin : g_bad_limit
      $error("ac_tmo: LIMIT must be at least 2");
   end

   assign expire = en && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (expire)  cnt <= '0;
      else if (en)      cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/ac_frame.sv
module ac_frame
   import ac_pkg::*;
#(
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned ARG_W   = 32,
   parameter int unsigned CRC_W   = 7,
   parameter logic [CRC_W-1:0] CRC_POLY = 7'h09,
   parameter int unsigned TIMEOUT = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cmd_in,
   input  logic             launch,
   input  logic [IDX_W-1:0] exp_idx,
   output logic             done,
   output logic             tmo,
   output ac_err_t          err
);
   localparam int unsigned CRC_END = 2 + IDX_W + ARG_W;
   localparam int unsigned FRAME   = CRC_END + CRC_W + 1;
   localparam int unsigned POS_W   = $clog2(FRAME);
   localparam logic [POS_W-1:0] P_IDX_LO = POS_W'(2);
   localparam logic [POS_W-1:0] P_IDX_HI = POS_W'(2 + IDX_W - 1);
   localparam logic [POS_W-1:0] P_CRC_LO = POS_W'(CRC_END);
   localparam logic [POS_W-1:0] P_CRC_HI = POS_W'(FRAME - 2);
   localparam logic [POS_W-1:0] P_LAST   = POS_W'(FRAME - 1);

   if (IDX_W < 2 || ARG_W < 1) begin : g_bad_fields
      $error("ac_frame: field widths too small");
   end

   ac_state_e        state;
   logic [POS_W-1:0] pos;
   logic [IDX_W-1:0] exp_q;
   logic [IDX_W-1:0] idx_sr;
   logic [CRC_W-1:0] rcrc_sr;
   logic [CRC_W-1:0] crc_calc;
   logic             smp;
   logic             waiting;
   logic             seen_start;
   logic             crc_en;
   logic             tmo_en;
   logic             tmo_hit;

   assign smp        = tick && (state != ST_IDLE);
   assign waiting    = smp && (state == ST_WAIT);
   assign seen_start = waiting && !cmd_in;
   assign tmo_en     = waiting && cmd_in;
   assign crc_en     = seen_start || (smp && state == ST_RECV && pos < P_CRC_LO);

   ac_crc_ser #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (launch),
      .en    (crc_en),
      .din   (cmd_in),
      .crc   (crc_calc)
   );

   ac_tmo #(.LIMIT(TIMEOUT)) u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (launch),
      .en     (tmo_en),
      .expire (tmo_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         pos     <= '0;
         exp_q   <= '0;
         idx_sr  <= '0;
         rcrc_sr <= '0;
      end else if (launch) begin
         state <= ST_WAIT;
         pos   <= '0;
         exp_q <= exp_idx;
      end else if (smp) begin
         unique case (state)
            ST_WAIT: begin
               if (!cmd_in) begin
                  state <= ST_RECV;
                  pos   <= POS_W'(1);
               end else if (tmo_hit) begin
                  state <= ST_IDLE;
               end
            end
            ST_RECV: begin
               if (pos >= P_IDX_LO && pos <= P_IDX_HI)
                  idx_sr <= {idx_sr[IDX_W-2:0], cmd_in};
               if (pos >= P_CRC_LO && pos <= P_CRC_HI)
                  rcrc_sr <= {rcrc_sr[CRC_W-2:0], cmd_in};
               if (pos == P_LAST) state <= ST_IDLE;
               else               pos   <= pos + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done     = smp && (state == ST_RECV) && (pos == P_LAST) && !launch;
   assign tmo      = tmo_hit && !launch;
   assign err.tmo  = tmo;
   assign err.crc  = done && (rcrc_sr != crc_calc);
   assign err.endb = done && !cmd_in;
   assign err.idx  = done && (idx_sr != exp_q);
endmodule

// File: rtl/ac_resp_check.sv
module ac_resp_check
   import ac_pkg::*;
#(
   parameter int unsigned IDX_W   = 6,
   parameter int unsigned ARG_W   = 32,
   parameter int unsigned CRC_W   = 7,
   parameter int unsigned TIMEOUT = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sd_tick,
   input  logic             cmd_in,
   input  logic             launch,
   input  logic             launch_kind,
   input  logic [IDX_W-1:0] launch_idx,
   input  logic             skip,
   input  logic             xfer_active,
   input  logic             cmd_pending,
   input  logic             clr,
   output logic [7:0]       status,
   output logic             err_strobe
);
   localparam logic [CRC_W-1:0] POLY = CRC_W'(7'h09);

   ac_src_e                 src_q;
   ac_err_t                 ferr;
   logic                    fdone;
   logic                    ftmo;
   logic [STAT_W-1:0]       nxt;
   logic                    any_rsp;
   logic                    rep;

   ac_frame #(
      .IDX_W    (IDX_W),
      .ARG_W    (ARG_W),
      .CRC_W    (CRC_W),
      .CRC_POLY (POLY),
      .TIMEOUT  (TIMEOUT)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (sd_tick),
      .cmd_in  (cmd_in),
      .launch  (launch),
      .exp_idx (launch_idx),
      .done    (fdone),
      .tmo     (ftmo),
      .err     (ferr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      src_q <= SRC_STOP;
      else if (launch) src_q <= ac_src_e'(launch_kind);
   end

   always_comb begin
      nxt     = '0;
      any_rsp = 1'b0;
      if (fdone || ftmo) begin
         nxt[POS_TMO] = ferr.tmo;
         if (!ferr.tmo) begin
            nxt[POS_CRC] = ferr.crc;
            nxt[POS_END] = ferr.endb;
            nxt[POS_IDX] = ferr.idx;
         end
         any_rsp      = |nxt[POS_IDX:POS_TMO];
         nxt[POS_CNI] = any_rsp && (src_q == SRC_STOP) && cmd_pending;
      end else if (skip && xfer_active) begin
         nxt[POS_NE] = 1'b1;
      end
   end

   assign rep = |nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status     <= '0;
         err_strobe <= 1'b0;
      end else if (rep) begin
         status     <= nxt;
         err_strobe <= 1'b1;
      end else begin
         err_strobe <= 1'b0;
         if (clr) status <= '0;
      end
   end
endmodule

// File: rtl/ac_resp_check_sva.sv
module ac_resp_check_sva (
   input logic       clk,
   input logic       rst_n,
   input logic       clr,
   input logic [7:0] status,
   input logic       err_strobe
);
   p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      status[6:5] == 2'b00);

   p_tmo_masks_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      status[1] |-> (status[4:2] == 3'b000));

   p_ne_alone_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] |-> (status[7:1] == 7'b0));

   p_cni_needs_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      status[7] |-> (status[4:1] != 4'b0));

   p_strobe_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_strobe |-> (status != 8'h00));

   p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_strobe |=> !err_strobe);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (err_strobe || $stable(status)));

   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (err_strobe || status == 8'h00));
endmodule

bind ac_resp_check ac_resp_check_sva u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr        (clr),
   .status     (status),
   .err_strobe (err_strobe)
);

// File: tb/sim_ac_resp_check.sv
module sim_ac_resp_check;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sd_tick = 1'b0;
   logic       cmd_in = 1'b1;
   logic       launch = 1'b0;
   logic       launch_kind = 1'b0;
   logic [5:0] launch_idx = '0;
   logic       skip = 1'b0;
   logic       xfer_active = 1'b0;
   logic       cmd_pending = 1'b0;
   logic       clr = 1'b0;
   logic [7:0] status;
   logic       err_strobe;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2 clk = ~clk;

   ac_resp_check u0 (
      .clk(clk), .rst_n(rst_n), .sd_tick(sd_tick), .cmd_in(cmd_in),
      .launch(launch), .launch_kind(launch_kind), .launch_idx(launch_idx),
      .skip(skip), .xfer_active(xfer_active), .cmd_pending(cmd_pending),
      .clr(clr), .status(status), .err_strobe(err_strobe)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got %0d cycles exp completion", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h exp %h", req, got, exp);
      end
   endtask

   function automatic logic [6:0] crc7(input logic [39:0] d);
      logic [6:0] c = '0;
      for (int i = 39; i >= 0; i--) begin
         logic fb = d[i] ^ c[6];
         c = {c[5:0], 1'b0};
         if (fb) c = c ^ 7'h09;
      end
      return c;
   endfunction

   // one SD bit: value on the tick cycle, inverted value in the off-tick cycle (R11)
   task automatic sdbit(input logic b);
      @(negedge clk);
      cmd_in  = b;
      sd_tick = 1'b1;
      @(negedge clk);
      sd_tick = 1'b0;
      cmd_in  = ~b;
   endtask

   task automatic do_launch(input logic kind, input logic [5:0] idx);
      @(negedge clk);
      launch      = 1'b1;
      launch_kind = kind;
      launch_idx  = idx;
      @(negedge clk);
      launch = 1'b0;
   endtask

   task automatic do_clear(input string req);
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      chk(req, status, 8'h00);
   endtask

   function automatic logic [7:0] expect_st(input logic to, input logic cb, input logic eb,
                                           input logic ib, input logic kind, input logic pend);
      logic [7:0] s = '0;
      if (to) s[1] = 1'b1;
      else begin
         s[2] = cb; s[3] = eb; s[4] = ib;
      end
      s[7] = (s[4:1] != 0) && !kind && pend;
      return s;
   endfunction

   // delay = high ticks before start bit; delay >= 64 means timeout expected
   task automatic respond(input string req, input logic kind, input logic [5:0] idx,
                          input logic [5:0] rx_idx, input logic [31:0] arg,
                          input logic flip, input logic endb, input logic pend,
                          input int delay);
      logic [39:0] head;
      logic [47:0] fr;
      logic [7:0]  e;
      logic        to;
      cmd_pending = pend;
      head = {2'b00, rx_idx, arg};
      fr   = {head, crc7(head) ^ (flip ? 7'h01 : 7'h00), endb};
      to   = (delay >= 64);
      do_launch(kind, idx);
      for (int i = 0; i < (to ? 64 : delay); i++) sdbit(1'b1);
      if (!to) for (int i = 47; i >= 0; i--) sdbit(fr[i]);
      e = expect_st(to, flip, !endb, rx_idx != idx, kind, pend);
      chk({req, " strobe"}, {7'b0, err_strobe}, {7'b0, e != 0});
      chk({req, " status"}, status, e);
      @(negedge clk);
      chk({req, " strobe drop R10"}, {7'b0, err_strobe}, 8'h00);
      if (e != 0) do_clear({req, " clear R10"});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R6 reset status", status, 8'h00);
      chk("R6 reset strobe", {7'b0, err_strobe}, 8'h00);
      rst_n = 1'b1;

      // R9 clean responses and R4 index mismatch over every index
      for (int k = 0; k < 64; k++) begin
         respond("R9 clean", 1'b0, 6'(k), 6'(k), 32'h1234_5678 ^ (32'(k) * 32'h0101_0101),
                 1'b0, 1'b1, 1'b1, k % 5);
         respond("R4 index", 1'b1, 6'(k), 6'(k) ^ 6'h21, 32'(k) << 7, 1'b0, 1'b1, 1'b0, 2);
      end
      // R2 crc, R3 end bit, R8 source and pending
      respond("R2 crc stop", 1'b0, 6'd12, 6'd12, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 1);
      respond("R2 R8 crc stop pend", 1'b0, 6'd12, 6'd12, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b1, 1);
      respond("R8 crc count pend", 1'b1, 6'd23, 6'd23, 32'h0000_0010, 1'b1, 1'b1, 1'b1, 0);
      respond("R3 end bit", 1'b0, 6'd12, 6'd12, 32'h0, 1'b0, 1'b0, 1'b0, 3);
      respond("R3 R8 end count", 1'b1, 6'd23, 6'd23, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 3);
      respond("R2 R3 R4 all", 1'b0, 6'd12, 6'd13, 32'hA5A5_5A5A, 1'b1, 1'b0, 1'b1, 0);
      // R1 timing boundary, R5 masking
      respond("R1 start on tick 64", 1'b0, 6'd12, 6'd12, 32'h7, 1'b0, 1'b1, 1'b1, 63);
      respond("R1 R5 timeout stop", 1'b0, 6'd12, 6'd12, 32'h7, 1'b0, 1'b1, 1'b1, 64);
      respond("R1 R5 R8 timeout count", 1'b1, 6'd23, 6'd23, 32'h7, 1'b0, 1'b1, 1'b1, 64);

      // R7 not-executed handling
      xfer_active = 1'b0;
      @(negedge clk); skip = 1'b1;
      @(negedge clk); skip = 1'b0;
      chk("R7 skip no xfer strobe", {7'b0, err_strobe}, 8'h00);
      chk("R7 skip no xfer status", status, 8'h00);
      xfer_active = 1'b1;
      cmd_pending = 1'b1;
      @(negedge clk); skip = 1'b1;
      @(negedge clk); skip = 1'b0;
      chk("R7 skip strobe", {7'b0, err_strobe}, 8'h01);
      chk("R7 skip status", status, 8'h01);
      repeat (5) @(negedge clk);
      chk("R10 hold status", status, 8'h01);
      chk("R10 hold strobe", {7'b0, err_strobe}, 8'h00);
      do_clear("R10 clear after skip");
      xfer_active = 1'b0;

      // R10 report wins over clear in the same cycle
      @(negedge clk); skip = 1'b1; xfer_active = 1'b1; clr = 1'b1;
      @(negedge clk); skip = 1'b0; xfer_active = 1'b0; clr = 1'b0;
      chk("R10 report over clear", status, 8'h01);
      do_clear("R10 clear final");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule